// File: doc/BRIEF.md
# Compressed-Key Searchable Entry Table

This block is a 32-entry table searched by content. Each key is 13 bits wide: a 7-bit device address, a 4-bit endpoint number and two single-bit flags. The main storage words are only 10 bits wide, so the full key cannot be kept directly. The address field also cannot be cut down, because its values are handed out by the host in no predictable pattern.

To close that gap, a small side table (default 4 slots) captures each real 7-bit address when it is assigned. A main entry then keeps only the slot number, 2 bits at the default depth, next to the endpoint and flags.

There are three ports:
- **Side-table port.** Loads an address into a slot when the address is assigned.
- **Main write port.** Stores a full key at a 5-bit entry address. The block turns the key's address into a slot number before storing it.
- **Search port.** Takes a full key. One clock later it reports whether a valid entry holds that key and, if so, the lowest such entry.

Because entries hold slot numbers, loading a new address into an occupied slot moves every entry that refers to that slot onto the new address.

Top module: `addr_compress_cam`

## Requirements
- R1: After reset, `srch_hit`, `srch_idx` and `wr_err` are 0. All side-table slots and main entries are empty, so every search misses.
- R2: Key layout is bits [12:6] address, [5:2] endpoint, [1] flag A, [0] flag B. Suppose `srch_en` is high on clock edge N, and a valid entry holds a key equal in all four fields, with its address still loaded in the slot that entry refers to. Then, after edge N, `srch_hit` is 1 and `srch_idx` gives that entry number.
- R3: When several valid entries match a searched key, `srch_idx` reports the lowest entry number.
- R4: A key that differs from every valid entry in the endpoint or in either flag misses. A miss gives `srch_hit` = 0 and `srch_idx` = 0.
- R5: A searched key whose address is held in no loaded side-table slot misses, whatever the other fields hold.
- R6: A main write whose address is held in no loaded slot is rejected. `wr_err` is 1 for the cycle after the write edge, and the target entry keeps its previous contents and validity.
- R7: A main write whose address is in the side table gives `wr_err` = 0. It makes the entry valid and replaces its previous key.
- R8: Loading a new address into a slot that entries already refer to moves those entries onto the new address. They match the new address and no longer match the old one. When the same address sits in two slots, the lower slot is used.
- R9: In the cycle after an edge where `srch_en` is low, `srch_hit` and `srch_idx` are 0.
- R10: A search and a write on the same edge see the tables as they were before that edge. This applies to a main write, and to a side-table load together with a main write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| side_we | input | 1 | Load the side-table slot |
| side_slot | input | 2 | Slot number to load |
| side_addr | input | 7 | Device address placed in the slot |
| wr_en | input | 1 | Main table write strobe |
| wr_idx | input | 5 | Main entry to write |
| wr_key | input | 13 | Full key to store |
| wr_err | output | 1 | Rejected-write pulse, one cycle |
| srch_en | input | 1 | Search strobe |
| srch_key | input | 13 | Full key to look up |
| srch_hit | output | 1 | A valid entry matched |
| srch_idx | output | 5 | Lowest matching entry, 0 on a miss |

## Verification
Every result is due exactly one clock after the edge that takes the request:
- `wr_err` follows the write edge.
- `srch_hit` and `srch_idx` follow the search edge.
- A table update becomes visible to searches only from the next edge on.

The bench drives each request at a falling edge and samples the outputs at the following falling edge. At that point the reference model predicts them from the table state before the request. The model is updated only after the comparison, so same-edge write and search cases are judged against the old contents.

// File: rtl/addr_compress_cam.sv
module addr_compress_cam #(
  parameter int ENTRIES = 32,
  parameter int ADDR_W  = 7,
  parameter int EP_W    = 4,
  parameter int SLOTS   = 4,
  parameter int WORD_W  = 10
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   side_we,
  input  logic [((SLOTS>1)?$clog2(SLOTS):1)-1:0] side_slot,
  input  logic [ADDR_W-1:0]                      side_addr,
  input  logic                                   wr_en,
  input  logic [$clog2(ENTRIES)-1:0]             wr_idx,
  input  logic [ADDR_W+EP_W+1:0]                 wr_key,
  output logic                                   wr_err,
  input  logic                                   srch_en,
  input  logic [ADDR_W+EP_W+1:0]                 srch_key,
  output logic                                   srch_hit,
  output logic [$clog2(ENTRIES)-1:0]             srch_idx
);
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int EIDX_W = $clog2(ENTRIES);
  localparam int KEY_W  = ADDR_W + EP_W + 2;
  localparam int TAIL_W = EP_W + 2;
  localparam int PACK_W = SLOT_W + TAIL_W;

  logic [ADDR_W-1:0] side_val [SLOTS];
  logic [SLOTS-1:0]  side_vld;
  logic [WORD_W-1:0] mem [ENTRIES];
  logic [ENTRIES-1:0] mem_vld;

  logic [SLOTS-1:0]   w_slot_hv, s_slot_hv;
  logic [ENTRIES-1:0] ent_hv;
  logic [SLOT_W-1:0]  w_slot, s_slot;
  logic               w_found, s_found;
  logic               ent_any;
  logic [EIDX_W-1:0]  ent_first;
  logic [WORD_W-1:0]  w_word, s_word;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign w_slot_hv[g] = side_vld[g] && (side_val[g] == wr_key[KEY_W-1 -: ADDR_W]);
    assign s_slot_hv[g] = side_vld[g] && (side_val[g] == srch_key[KEY_W-1 -: ADDR_W]);
  end

  always_comb begin
    w_found = |w_slot_hv;
    s_found = |s_slot_hv;
    w_slot  = '0;
    s_slot  = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (w_slot_hv[i]) w_slot = SLOT_W'(i);
      if (s_slot_hv[i]) s_slot = SLOT_W'(i);
    end
  end

  assign w_word = WORD_W'({w_slot, wr_key[TAIL_W-1:0]});
  assign s_word = WORD_W'({s_slot, srch_key[TAIL_W-1:0]});

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    assign ent_hv[e] = mem_vld[e] && s_found && (mem[e] == s_word);
  end

  always_comb begin
    ent_any   = |ent_hv;
    ent_first = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (ent_hv[i]) ent_first = EIDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (side_we) side_val[side_slot] <= side_addr;
    if (wr_en && w_found) mem[wr_idx] <= w_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      side_vld <= '0;
      mem_vld  <= '0;
      wr_err   <= 1'b0;
      srch_hit <= 1'b0;
      srch_idx <= '0;
    end else begin
      if (side_we) side_vld[side_slot] <= 1'b1;
      if (wr_en && w_found) mem_vld[wr_idx] <= 1'b1;
      wr_err   <= wr_en && !w_found;
      srch_hit <= srch_en && ent_any;
      srch_idx <= (srch_en && ent_any) ? ent_first : '0;
    end
  end

  p_miss_idx_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_hit |-> srch_idx == '0);
  p_quiet_without_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(srch_en) |-> !srch_hit);
  p_err_needs_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(wr_en));
  p_hit_needs_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    srch_hit |-> $past(|side_vld));
  p_slot_valid_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(side_vld) & ~side_vld) == '0);
  p_pack_fits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    PACK_W <= WORD_W);
endmodule

// File: tb/sim_addr_compress_cam.sv
`timescale 1ns/1ps
module sim_addr_compress_cam;
  logic clk = 1'b0, rst_n = 1'b0;
  logic side_we = 0, wr_en = 0, srch_en = 0;
  logic [1:0] side_slot = 0;
  logic [6:0] side_addr = 0;
  logic [4:0] wr_idx = 0;
  logic [12:0] wr_key = 0, srch_key = 0;
  logic wr_err, srch_hit;
  logic [4:0] srch_idx;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  addr_compress_cam u0 (.clk(clk), .rst_n(rst_n), .side_we(side_we), .side_slot(side_slot),
    .side_addr(side_addr), .wr_en(wr_en), .wr_idx(wr_idx), .wr_key(wr_key), .wr_err(wr_err),
    .srch_en(srch_en), .srch_key(srch_key), .srch_hit(srch_hit), .srch_idx(srch_idx));

  logic [6:0] m_sa [4];
  bit         m_sv [4];
  int         m_slot [32];
  logic [5:0] m_tail [32];
  bit         m_v [32];

  function automatic int lookup(input logic [6:0] a);
    for (int i = 0; i < 4; i++) if (m_sv[i] && m_sa[i] == a) return i;
    return -1;
  endfunction

  function automatic int exp_search(input logic [12:0] k);
    int s = lookup(k[12:6]);
    if (s < 0) return -1;
    for (int i = 0; i < 32; i++)
      if (m_v[i] && m_slot[i] == s && m_tail[i] == k[5:0]) return i;
    return -1;
  endfunction

  function automatic logic [12:0] mk(input logic [6:0] a, input logic [3:0] ep,
                                     input bit fa, input bit fb);
    return {a, ep, fa, fb};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit sw, input int ss, input logic [6:0] sa,
                     input bit mw, input int mi, input logic [12:0] wk,
                     input bit se, input logic [12:0] sk, input string tag);
    int e_srch, wslot;
    bit e_err;
    side_we = sw; side_slot = ss[1:0]; side_addr = sa;
    wr_en = mw; wr_idx = mi[4:0]; wr_key = wk;
    srch_en = se; srch_key = sk;
    wslot  = lookup(wk[12:6]);
    e_err  = mw && wslot < 0;
    e_srch = se ? exp_search(sk) : -1;
    @(negedge clk);
    chk({tag, " err"}, int'(wr_err), int'(e_err));
    chk({tag, " hit"}, int'(srch_hit), int'(e_srch >= 0));
    chk({tag, " idx"}, int'(srch_idx), (e_srch >= 0) ? e_srch : 0);
    if (sw) begin m_sa[ss] = sa; m_sv[ss] = 1; end
    if (mw && !e_err) begin m_slot[mi] = wslot; m_tail[mi] = wk[5:0]; m_v[mi] = 1; end
    side_we = 0; wr_en = 0; srch_en = 0;
  endtask

  function automatic logic [6:0] pool_addr();
    case ($urandom % 6)
      0: return 7'h05; 1: return 7'h12; 2: return 7'h7F;
      3: return 7'h00; 4: return 7'h40; default: return 7'h33;
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [12:0] ka, kb, kn;
    for (int i = 0; i < 4; i++) begin m_sv[i] = 0; m_sa[i] = 0; end
    for (int i = 0; i < 32; i++) begin m_v[i] = 0; m_slot[i] = 0; m_tail[i] = 0; end
    void'($urandom(32'd20231));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 hit", int'(srch_hit), 0);
    chk("R1 idx", int'(srch_idx), 0);
    chk("R1 err", int'(wr_err), 0);
    ka = mk(7'h2A, 4'd5, 1, 0);
    kb = mk(7'h2A, 4'd9, 0, 1);
    cyc(0, 0, 0, 0, 0, 0, 1, ka, "R1");
    // R6 write with empty side table
    cyc(0, 0, 0, 1, 3, ka, 0, 0, "R6");
    cyc(0, 0, 0, 0, 0, 0, 1, ka, "R6");
    cyc(1, 2, 7'h2A, 0, 0, 0, 0, 0, "R2");
    cyc(0, 0, 0, 1, 3, ka, 0, 0, "R7");
    cyc(0, 0, 0, 0, 0, 0, 1, ka, "R2");
    cyc(0, 0, 0, 1, 1, ka, 0, 0, "R7");
    cyc(0, 0, 0, 0, 0, 0, 1, ka, "R3");
    cyc(0, 0, 0, 0, 0, 0, 1, mk(7'h2A, 4'd5, 1, 1), "R4");
    cyc(0, 0, 0, 0, 0, 0, 1, mk(7'h2A, 4'd4, 1, 0), "R4");
    cyc(0, 0, 0, 0, 0, 0, 1, mk(7'h2B, 4'd5, 1, 0), "R5");
    cyc(0, 0, 0, 0, 0, 0, 0, ka, "R9");
    cyc(0, 0, 0, 1, 1, kb, 0, 0, "R7");
    cyc(0, 0, 0, 0, 0, 0, 1, ka, "R7");
    cyc(0, 0, 0, 0, 0, 0, 1, kb, "R7");
    // R10 same-edge write and search
    cyc(0, 0, 0, 1, 0, ka, 1, ka, "R10");
    cyc(0, 0, 0, 0, 0, 0, 1, ka, "R10");
    // R10 side load with main write on same edge: write uses old table
    cyc(1, 1, 7'h11, 1, 5, mk(7'h11, 4'd1, 0, 0), 0, 0, "R10");
    // R6 rejected write leaves entry 0 unchanged
    cyc(0, 0, 0, 1, 0, mk(7'h6C, 4'd1, 0, 0), 0, 0, "R6");
    cyc(0, 0, 0, 0, 0, 0, 1, ka, "R6");
    // R8 retarget slot 2
    kn = mk(7'h55, 4'd5, 1, 0);
    cyc(1, 2, 7'h55, 0, 0, 0, 0, 0, "R8");
    cyc(0, 0, 0, 0, 0, 0, 1, ka, "R8");
    cyc(0, 0, 0, 0, 0, 0, 1, kn, "R8");
    // R8 duplicate address in two slots: lower slot wins
    cyc(1, 0, 7'h55, 0, 0, 0, 0, 0, "R8");
    cyc(0, 0, 0, 0, 0, 0, 1, kn, "R8");
    cyc(0, 0, 0, 1, 7, kn, 0, 0, "R8");
    cyc(0, 0, 0, 0, 0, 0, 1, kn, "R8");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      bit sw, mw, se;
      logic [12:0] wk, sk;
      int j;
      sw = ($urandom % 10) == 0;
      mw = ($urandom % 3) == 0;
      se = ($urandom % 4) != 0;
      wk = mk(pool_addr(), 4'($urandom % 4), 1'($urandom), 1'($urandom));
      sk = mk(pool_addr(), 4'($urandom % 4), 1'($urandom), 1'($urandom));
      j = int'($urandom % 32);
      if (($urandom % 2) == 0 && m_v[j] && m_sv[m_slot[j]])
        sk = {m_sa[m_slot[j]], m_tail[j]};
      cyc(sw, int'($urandom % 4), pool_addr(), mw, int'($urandom % 32), wk, se, sk,
          "R2/R3/R4/R5/R6/R7");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule